// File: doc/BRIEF.md
# Two-Stage Signed Energy Integrator

This block takes a signed power value and integrates it in two stages. On every cycle where the sample strobe is high, the value is added into a 42-bit signed internal total. When an update event arrives, the internal total moves into a 45-bit signed user energy register. The move either replaces the register or adds to it, as a mode input selects. The internal total then restarts from zero.

Software reads the user register as two 32-bit words. The lower word carries bits 31 to 0. The upper word carries bits 44 to 32, sign-extended to 32 bits.

The block handles a single channel. A design with several phases uses one instance per phase. The power source and the event that paces the transfers live outside the block.

Top module: `egy_integrator`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the internal total and the user register. Both words read zero after reset, and a transfer in overwrite mode with no samples taken gives zero.
- R2: The internal total changes only on an edge where `sampleStb` is high. On that edge it gains `pwrIn`, sign-extended. When the strobe is low, `pwrIn` has no effect.
- R3: When `loadMode` is 0, an update event adds the sign-extended internal total to the user register.
- R4: When `loadMode` is 1, an update event replaces the user register with the sign-extended internal total.
- R5: On every update event the internal total is cleared to zero. The next transfer carries only samples taken after that event.
- R6: When `sampleStb` and `updateEvt` are both high on the same edge, that cycle's sample is part of the transferred total. The internal total still restarts at zero.
- R7: The internal total wraps modulo 2^42 and is not saturated.
- R8: The user register wraps modulo 2^45 and is not saturated.
- R9: `energyLo` equals user bits [31:0]. `energyHi` equals user bits [44:32] in its bits [12:0], and its bits [31:13] are copies of bit 44.
- R10: The user register holds its value on any edge without an update event.
- R11: A negative internal total reaches the user register with its sign preserved (42-bit to 45-bit sign extension).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleStb | input | 1 | One-cycle DSP sample strobe |
| updateEvt | input | 1 | One-cycle update event (transfer to user register) |
| loadMode | input | 1 | 1 = overwrite user register, 0 = add to it |
| pwrIn | input | 32 | Signed per-sample power value |
| energyLo | output | 32 | User register bits [31:0] |
| energyHi | output | 32 | User register bits [44:32], sign-extended |

## Verification
The hardest states to reach are the wrap points, because both totals are far wider than one input sample. The bench fills the internal total with more than a thousand full-scale positive samples to push it past 2^41. It then chains nine near-full internal totals in add mode so that the user register crosses 2^44. A same-cycle sample and update is driven on purpose. The transfer after it is checked to carry only later samples.

// File: rtl/egy_pkg.sv
package egy_pkg;
  typedef struct packed {
    logic addSample;
    logic xfer;
    logic clrInt;
    logic overwrite;
  } egy_ctrl_t;
endpackage

// File: rtl/egy_ctrl.sv
module egy_ctrl (
  input  logic              rst,
  input  logic              sampleStb,
  input  logic              updateEvt,
  input  logic              loadMode,
  output egy_pkg::egy_ctrl_t ctl
);
  always_comb begin
    ctl.addSample = sampleStb & ~rst;
    ctl.xfer      = updateEvt & ~rst;
    ctl.clrInt    = updateEvt | rst;
    ctl.overwrite = loadMode;
  end
endmodule

// File: rtl/egy_datapath.sv
module egy_datapath #(
  parameter int PWR_W = 32,
  parameter int INT_W = 42,
  parameter int USR_W = 45
) (
  input  logic                     clk,
  input  logic                     rst,
  input  egy_pkg::egy_ctrl_t       ctl,
  input  logic signed [PWR_W-1:0]  pwrIn,
  output logic signed [INT_W-1:0]  intAcc,
  output logic signed [USR_W-1:0]  userReg
);
  localparam int INT_PAD = INT_W - PWR_W;
  localparam int USR_PAD = USR_W - INT_W;

  logic signed [INT_W-1:0] sampleTerm;
  logic signed [INT_W-1:0] intNext;
  logic signed [USR_W-1:0] xferVal;
  logic signed [USR_W-1:0] userNext;

  always_comb begin
    sampleTerm = ctl.addSample ? {{INT_PAD{pwrIn[PWR_W-1]}}, pwrIn} : '0;
    intNext    = intAcc + sampleTerm;
    xferVal    = {{USR_PAD{intNext[INT_W-1]}}, intNext};
    userNext   = ctl.overwrite ? xferVal : userReg + xferVal;
  end

  always_ff @(posedge clk) begin
    if (ctl.clrInt)         intAcc <= '0;
    else if (ctl.addSample) intAcc <= intNext;
    if (rst)                userReg <= '0;
    else if (ctl.xfer)      userReg <= userNext;
  end
endmodule

// File: rtl/egy_readout.sv
module egy_readout #(
  parameter int USR_W  = 45,
  parameter int WORD_W = 32,
  localparam int NUM_WORDS = (USR_W + WORD_W - 1) / WORD_W
) (
  input  logic [USR_W-1:0]                   userReg,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]   words
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int LO = w * WORD_W;
    if (LO + WORD_W <= USR_W) begin : g_full
      assign words[w] = userReg[LO+WORD_W-1:LO];
    end else begin : g_part
      assign words[w] = {{(LO+WORD_W-USR_W){userReg[USR_W-1]}}, userReg[USR_W-1:LO]};
    end
  end
endmodule

// File: rtl/egy_integrator.sv
module egy_integrator #(
  parameter int PWR_W  = 32,
  parameter int INT_W  = 42,
  parameter int USR_W  = 45,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleStb,
  input  logic              updateEvt,
  input  logic              loadMode,
  input  logic [PWR_W-1:0]  pwrIn,
  output logic [WORD_W-1:0] energyLo,
  output logic [WORD_W-1:0] energyHi
);
  localparam int NUM_WORDS = (USR_W + WORD_W - 1) / WORD_W;

  egy_pkg::egy_ctrl_t ctl;
  logic signed [INT_W-1:0] intTotal;
  logic signed [USR_W-1:0] userTotal;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;

  egy_ctrl u_ctrl (
    .rst(rst), .sampleStb(sampleStb), .updateEvt(updateEvt),
    .loadMode(loadMode), .ctl(ctl)
  );

  egy_datapath #(.PWR_W(PWR_W), .INT_W(INT_W), .USR_W(USR_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .pwrIn(pwrIn),
    .intAcc(intTotal), .userReg(userTotal)
  );

  egy_readout #(.USR_W(USR_W), .WORD_W(WORD_W)) u_rd (
    .userReg(userTotal), .words(words)
  );

  assign energyLo = words[0];
  assign energyHi = words[NUM_WORDS-1];
endmodule

// File: rtl/egy_integrator_chk.sv
module egy_integrator_chk #(
  parameter int INT_W  = 42,
  parameter int USR_W  = 45,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sampleStb,
  input logic              updateEvt,
  input logic              loadMode,
  input logic [WORD_W-1:0] energyLo,
  input logic [WORD_W-1:0] energyHi,
  input logic [INT_W-1:0]  intAcc,
  input logic [USR_W-1:0]  userReg
);
  localparam int PAD = USR_W - INT_W;
  localparam int HI_SIGN = 2 * WORD_W - USR_W;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (energyLo == '0 && energyHi == '0 && intAcc == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sampleStb && !updateEvt) |=> $stable(intAcc)); // R2

  AST_ADD_XFER: assert property (@(posedge clk) disable iff (rst)
    (updateEvt && !loadMode && !sampleStb) |=>
      userReg == $past(userReg) + {{PAD{$past(intAcc[INT_W-1])}}, $past(intAcc)}); // R3

  AST_LOAD_XFER: assert property (@(posedge clk) disable iff (rst)
    (updateEvt && loadMode && !sampleStb) |=>
      userReg == {{PAD{$past(intAcc[INT_W-1])}}, $past(intAcc)}); // R4

  AST_CLEAR_AFTER: assert property (@(posedge clk) disable iff (rst)
    updateEvt |=> intAcc == '0); // R5

  AST_USER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !updateEvt |=> $stable({energyHi, energyLo})); // R10

  AST_WORD_SPLIT: assert property (@(posedge clk) disable iff (rst)
    energyLo == userReg[WORD_W-1:0] &&
    energyHi[WORD_W-1:USR_W-WORD_W] == {HI_SIGN{userReg[USR_W-1]}}); // R9
endmodule

bind egy_integrator egy_integrator_chk #(
  .INT_W(INT_W), .USR_W(USR_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .sampleStb(sampleStb), .updateEvt(updateEvt),
  .loadMode(loadMode), .energyLo(energyLo), .energyHi(energyHi),
  .intAcc(intTotal), .userReg(userTotal)
);

// File: tb/sim_egy_integrator.sv
module sim_egy_integrator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleStb = 1'b0;
  logic updateEvt = 1'b0;
  logic loadMode = 1'b0;
  logic [31:0] pwrIn = '0;
  logic [31:0] energyLo;
  logic [31:0] energyHi;

  int nChecks = 0;
  int nFails = 0;
  longint expInt = 0;
  longint expUser = 0;

  always #2 clk = ~clk;

  egy_integrator u0 (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .updateEvt(updateEvt),
    .loadMode(loadMode), .pwrIn(pwrIn), .energyLo(energyLo), .energyHi(energyHi)
  );

  function automatic longint wrapS(longint v, int w);
    longint t;
    t = v << (64 - w);
    return t >>> (64 - w);
  endfunction

  task automatic step(input logic stb, input logic evt, input logic mode,
                      input logic signed [31:0] pwr);
    longint sum;
    @(negedge clk);
    sampleStb = stb; updateEvt = evt; loadMode = mode; pwrIn = pwr;
    sum = wrapS(expInt + (stb ? longint'(pwr) : 0), 42);
    if (evt) begin
      expUser = mode ? sum : wrapS(expUser + sum, 45);
      expInt = 0;
    end else begin
      expInt = sum;
    end
    @(posedge clk);
    #1;
    sampleStb = 1'b0; updateEvt = 1'b0; pwrIn = '0;
  endtask

  task automatic checkWords(input string req);
    logic [63:0] e;
    e = 64'(wrapS(expUser, 45));
    nChecks++;
    if (energyLo !== e[31:0] || energyHi !== e[63:32]) begin
      nFails++;
      $display("FAIL %s: actual hi=%h lo=%h expected hi=%h lo=%h",
               req, energyHi, energyLo, e[63:32], e[31:0]);
    end
  endtask

  task automatic checkRaw(input string req, input logic [31:0] expHi,
                          input logic [31:0] expLo);
    nChecks++;
    if (energyLo !== expLo || energyHi !== expHi) begin
      nFails++;
      $display("FAIL %s: actual hi=%h lo=%h expected hi=%h lo=%h",
               req, energyHi, energyLo, expHi, expLo);
    end
  endtask

  task automatic tReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checkRaw("R1 words after reset", 32'h0, 32'h0);
    @(negedge clk); rst = 1'b0;
    expInt = 0; expUser = 0;
    step(1'b0, 1'b1, 1'b1, 32'sd0);
    checkRaw("R1 internal empty after reset", 32'h0, 32'h0);
  endtask

  task automatic tAccumLoad();
    step(1'b1, 1'b0, 1'b0, 32'sd100);
    step(1'b0, 1'b0, 1'b0, 32'sd999);
    step(1'b1, 1'b0, 1'b0, -32'sd30);
    step(1'b0, 1'b0, 1'b0, -32'sd5000);
    checkRaw("R10 user holds without update", 32'h0, 32'h0);
    step(1'b1, 1'b0, 1'b0, 32'sd5);
    step(1'b0, 1'b1, 1'b1, 32'sd777);
    checkRaw("R2 R4 load of 75 (unstrobed input ignored)", 32'h0, 32'd75);
    checkWords("R4 load model");
  endtask

  task automatic tAdd();
    step(1'b1, 1'b0, 1'b0, 32'sd10);
    step(1'b1, 1'b0, 1'b0, 32'sd20);
    step(1'b0, 1'b1, 1'b0, 32'sd0);
    checkRaw("R3 add 30 to 75", 32'h0, 32'd105);
    step(1'b0, 1'b1, 1'b0, 32'sd0);
    checkRaw("R5 second add carries nothing", 32'h0, 32'd105);
    step(1'b1, 1'b0, 1'b0, 32'sd1);
    step(1'b0, 1'b0, 1'b0, 32'sd0);
    checkRaw("R10 user holds while sampling", 32'h0, 32'd105);
  endtask

  task automatic tSameCycle();
    step(1'b0, 1'b1, 1'b1, 32'sd0);
    step(1'b1, 1'b0, 1'b0, 32'sd7);
    step(1'b1, 1'b1, 1'b1, 32'sd3);
    checkRaw("R6 same-cycle sample included", 32'h0, 32'd10);
    step(1'b0, 1'b1, 1'b1, 32'sd0);
    checkRaw("R6 R5 restart at zero after same-cycle", 32'h0, 32'h0);
  endtask

  task automatic tNegative();
    step(1'b1, 1'b0, 1'b0, -32'sd5);
    step(1'b0, 1'b1, 1'b1, 32'sd0);
    checkRaw("R11 R9 negative load sign-extended", 32'hFFFF_FFFF, 32'hFFFF_FFFB);
    step(1'b1, 1'b0, 1'b0, -32'sd2);
    step(1'b0, 1'b1, 1'b0, 32'sd0);
    checkRaw("R3 R11 add negative", 32'hFFFF_FFFF, 32'hFFFF_FFF9);
  endtask

  task automatic tHiWord();
    for (int i = 0; i < 1024; i++) step(1'b1, 1'b0, 1'b0, 32'sh7FFF_FFFF);
    step(1'b0, 1'b1, 1'b1, 32'sd0);
    checkRaw("R9 positive upper word", 32'h0000_01FF, 32'hFFFF_FC00);
  endtask

  task automatic tIntWrap();
    for (int i = 0; i < 1025; i++) step(1'b1, 1'b0, 1'b0, 32'sh7FFF_FFFF);
    step(1'b0, 1'b1, 1'b1, 32'sd0);
    checkWords("R7 internal wrap model");
    checkRaw("R7 internal wrap value", 32'hFFFF_FE00, 32'h7FFF_FBFF);
  endtask

  task automatic tUserWrap();
    step(1'b0, 1'b1, 1'b1, 32'sd0);
    for (int k = 0; k < 9; k++) begin
      for (int i = 0; i < 1024; i++) step(1'b1, 1'b0, 1'b0, 32'sh7FFF_FFFF);
      step(1'b0, 1'b1, 1'b0, 32'sd0);
    end
    checkWords("R8 user wrap model");
    checkRaw("R8 user wrap value", 32'hFFFF_F1FF, 32'hFFFF_DC00);
  endtask

  task automatic tMidReset();
    step(1'b1, 1'b0, 1'b0, 32'sd44);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    checkRaw("R1 reset clears user mid-run", 32'h0, 32'h0);
    @(negedge clk); rst = 1'b0;
    expInt = 0; expUser = 0;
    step(1'b0, 1'b1, 1'b0, 32'sd0);
    checkRaw("R1 reset clears internal mid-run", 32'h0, 32'h0);
  endtask

  initial begin
    tReset();
    tAccumLoad();
    tAdd();
    tSameCycle();
    tNegative();
    tHiWord();
    tIntWrap();
    tUserWrap();
    tMidReset();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule